// File: doc/BRIEF.md
# Address Region Read/Write Firewall

This block sits between untrusted processor cores and an on-chip SRAM and decides, request by request, whether an access may reach the memory. Every request carries an address, a direction flag (read or write) and a source tag that marks it as trusted or untrusted. A trusted request always goes through. An untrusted request is compared with a set of address windows. Each window grants read rights and write rights as two separate bits, so a window can be read-write, read-only or write-only.

The decision is combinational. A request that passes appears on the memory-side request port in the cycle it arrives. A refused request never reaches memory, so a refused write is dropped. A refusal also raises a one-cycle refusal strobe. It sets a sticky violation flag that records the address and direction of the first refused access. A clear input resets this record.

The default configuration has two windows. The first, 0xA0000000..0xA000FFFF, is read-write for untrusted agents. The second, 0xA0010000..0xA001FFFF, is read-only. Both bounds of each window are inclusive. Window bounds and rights are fixed by parameters when the block is built.

Top module: `addr_rw_firewall`

## Requirements
- R1: A valid request with `req_trusted`=1 is forwarded (`mem_req`=1 in the same cycle) whatever its address and direction, and it never causes a refusal.
- R2: An untrusted read with an address in 0xA0000000..0xA000FFFF (inclusive) is forwarded in the same cycle.
- R3: An untrusted write with an address in 0xA0000000..0xA000FFFF (inclusive) is forwarded in the same cycle.
- R4: An untrusted read with an address in 0xA0010000..0xA001FFFF (inclusive) is forwarded in the same cycle.
- R5: An untrusted write into 0xA0010000..0xA001FFFF is refused. `mem_req` stays 0 and `req_refused` is 1 in that cycle.
- R6: An untrusted read or write with an address outside both windows is refused, with `mem_req`=0 and `req_refused`=1.
- R7: After a refusal, `viol_flag` is 1 from the next clock edge. `viol_addr` and `viol_write` (1 = write) hold the address and direction of the first refused request. Later refusals do not change them until a clear.
- R8: `clear_viol`=1 empties the record at the next edge. If a refusal arrives in the same cycle as the clear, the record afterwards holds that new refusal.
- R9: `mem_req` is 0 when `req_valid` is 0. When `mem_req` is 1, `mem_addr`, `mem_write` and `mem_wdata` equal the request fields.
- R10: After reset, `viol_flag`=0, `viol_addr`=0 and `viol_write`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_trusted | input | 1 | 1 = request from a trusted source |
| clear_viol | input | 1 | Empty the violation record |
| mem_req | output | 1 | Forwarded request to memory |
| mem_addr | output | ADDR_W | Forwarded address |
| mem_write | output | 1 | Forwarded direction |
| mem_wdata | output | DATA_W | Forwarded write data |
| req_refused | output | 1 | Request refused this cycle |
| viol_flag | output | 1 | Sticky violation flag |
| viol_addr | output | ADDR_W | Address of first refused request |
| viol_write | output | 1 | Direction of first refused request |

## Verification
A refusal and a clear of the violation record can happen in the same clock cycle. The record must then hold the new offender and not come out empty. The bench provokes this case directly, with a refused write to the read-only window and a clear asserted together. Random traffic also asserts the clear in about one cycle in sixteen while refusals are frequent, so the collision also occurs many times with different addresses. A reference model updates at each edge. It is compared with the flag, address and direction at every following falling edge.

// File: rtl/fw_pkg.sv
package fw_pkg;

    typedef enum logic [1:0] {
        VERDICT_IDLE = 2'd0,
        VERDICT_PASS = 2'd1,
        VERDICT_DENY = 2'd2
    } verdict_e;

endpackage

// File: rtl/fw_region_match.sv
module fw_region_match #(
    parameter int ADDR_W      = 32,
    parameter int NUM_REGIONS = 2,
    parameter logic [NUM_REGIONS*ADDR_W-1:0] REGION_BASE  = '0,
    parameter logic [NUM_REGIONS*ADDR_W-1:0] REGION_LIMIT = '0
) (
    input  logic [ADDR_W-1:0]      addr_i,
    output logic [NUM_REGIONS-1:0] sel_o
);
    logic [NUM_REGIONS-1:0] hit_vec;

    // One comparator pair per window, inclusive at both ends.
    genvar g;
    generate
        for (g = 0; g < NUM_REGIONS; g++) begin : g_win
            localparam logic [ADDR_W-1:0] LO = REGION_BASE[g*ADDR_W +: ADDR_W];
            localparam logic [ADDR_W-1:0] HI = REGION_LIMIT[g*ADDR_W +: ADDR_W];
            assign hit_vec[g] = (addr_i >= LO) && (addr_i <= HI);
        end
    endgenerate

    // Lowest-numbered window wins when windows overlap.
    always_comb begin
        sel_o = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel_o    = '0;
                sel_o[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fw_verdict.sv
module fw_verdict
    import fw_pkg::*;
#(
    parameter int NUM_REGIONS = 2,
    parameter logic [NUM_REGIONS-1:0] RD_MASK = '1,
    parameter logic [NUM_REGIONS-1:0] WR_MASK = '0
) (
    input  logic                   valid_i,
    input  logic                   write_i,
    input  logic                   trusted_i,
    input  logic [NUM_REGIONS-1:0] sel_i,
    output verdict_e               verdict_o
);
    logic right_ok;

    always_comb begin
        // Rights are looked up per direction; no window shares one bit for both.
        if (write_i) right_ok = |(sel_i & WR_MASK);
        else         right_ok = |(sel_i & RD_MASK);

        if (!valid_i)                 verdict_o = VERDICT_IDLE;
        else if (trusted_i)           verdict_o = VERDICT_PASS;
        else if (right_ok)            verdict_o = VERDICT_PASS;
        else                          verdict_o = VERDICT_DENY;
    end
endmodule

// File: rtl/fw_viol_log.sv
module fw_viol_log #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deny_i,
    input  logic [ADDR_W-1:0] deny_addr_i,
    input  logic              deny_write_i,
    input  logic              clear_i,
    output logic              flag_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              write_o
);
    typedef struct packed {
        logic              flag;
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } log_t;

    log_t log_d, log_q;

    always_comb begin
        log_d = log_q;
        if (clear_i) log_d = '0;
        // A refusal in the clear cycle survives the clear.
        if (deny_i && (!log_q.flag || clear_i)) begin
            log_d.flag = 1'b1;
            log_d.wr   = deny_write_i;
            log_d.addr = deny_addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) log_q <= '0;
        else        log_q <= log_d;
    end

    assign flag_o  = log_q.flag;
    assign addr_o  = log_q.addr;
    assign write_o = log_q.wr;
endmodule

// File: rtl/addr_rw_firewall.sv
module addr_rw_firewall
    import fw_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int NUM_REGIONS = 2,
    parameter logic [NUM_REGIONS*ADDR_W-1:0] REGION_BASE  = {32'hA001_0000, 32'hA000_0000},
    parameter logic [NUM_REGIONS*ADDR_W-1:0] REGION_LIMIT = {32'hA001_FFFF, 32'hA000_FFFF},
    parameter logic [NUM_REGIONS-1:0] RD_MASK = 2'b11,
    parameter logic [NUM_REGIONS-1:0] WR_MASK = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_trusted,
    input  logic              clear_viol,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_write,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              req_refused,
    output logic              viol_flag,
    output logic [ADDR_W-1:0] viol_addr,
    output logic              viol_write
);
    logic [NUM_REGIONS-1:0] region_sel;
    verdict_e               verdict;

    fw_region_match #(
        .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS),
        .REGION_BASE(REGION_BASE), .REGION_LIMIT(REGION_LIMIT)
    ) u_match (
        .addr_i(req_addr),
        .sel_o (region_sel)
    );

    fw_verdict #(
        .NUM_REGIONS(NUM_REGIONS), .RD_MASK(RD_MASK), .WR_MASK(WR_MASK)
    ) u_verdict (
        .valid_i  (req_valid),
        .write_i  (req_write),
        .trusted_i(req_trusted),
        .sel_i    (region_sel),
        .verdict_o(verdict)
    );

    assign mem_req     = (verdict == VERDICT_PASS);
    assign req_refused = (verdict == VERDICT_DENY);
    assign mem_addr    = req_addr;
    assign mem_write   = req_write;
    assign mem_wdata   = req_wdata;

    fw_viol_log #(.ADDR_W(ADDR_W)) u_log (
        .clk         (clk),
        .rst_n       (rst_n),
        .deny_i      (req_refused),
        .deny_addr_i (req_addr),
        .deny_write_i(req_write),
        .clear_i     (clear_viol),
        .flag_o      (viol_flag),
        .addr_o      (viol_addr),
        .write_o     (viol_write)
    );
endmodule

// File: rtl/fw_checker.sv
module fw_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_trusted,
    input logic              clear_viol,
    input logic              mem_req,
    input logic              req_refused,
    input logic              viol_flag,
    input logic [ADDR_W-1:0] viol_addr,
    input logic              viol_write
);
    p_trusted_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_trusted) |-> (mem_req && !req_refused));

    p_refused_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_refused |-> !mem_req);

    p_refuse_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_refused |=> viol_flag);

    p_record_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && !clear_viol) |=> (viol_flag && $stable(viol_addr) && $stable(viol_write)));

    p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_viol && !req_refused) |=> !viol_flag);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!mem_req && !req_refused));

    p_flag_needs_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!viol_flag && !req_refused) |=> !viol_flag);
endmodule

bind addr_rw_firewall fw_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_trusted(req_trusted),
    .clear_viol(clear_viol), .mem_req(mem_req), .req_refused(req_refused),
    .viol_flag(viol_flag), .viol_addr(viol_addr), .viol_write(viol_write)
);

// File: tb/addr_rw_firewall_test.sv
`timescale 1ns/1ps
module addr_rw_firewall_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_trusted = 1'b0, clear_viol = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        mem_req, mem_write, req_refused, viol_flag, viol_write;
    logic [31:0] mem_addr, mem_wdata, viol_addr;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // Reference record
    logic        m_flag = 0, m_wr = 0;
    logic [31:0] m_addr = '0;

    always #2.5 clk = ~clk;

    addr_rw_firewall uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_trusted(req_trusted),
        .clear_viol(clear_viol), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_write(mem_write), .mem_wdata(mem_wdata), .req_refused(req_refused),
        .viol_flag(viol_flag), .viol_addr(viol_addr), .viol_write(viol_write)
    );

    function automatic bit exp_pass(logic [31:0] a, logic w, logic t);
        if (t) return 1'b1;
        if (a >= 32'hA000_0000 && a <= 32'hA000_FFFF) return 1'b1;
        if (a >= 32'hA001_0000 && a <= 32'hA001_FFFF) return !w;
        return 1'b0;
    endfunction

    function automatic string tag_of(logic [31:0] a, logic w, logic t);
        if (t) return "R1";
        if (a >= 32'hA000_0000 && a <= 32'hA000_FFFF) return w ? "R3" : "R2";
        if (a >= 32'hA001_0000 && a <= 32'hA001_FFFF) return w ? "R5" : "R4";
        return "R6";
    endfunction

    task automatic cmp(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_record(string req);
        cmp(req, "viol_flag", 64'(viol_flag), 64'(m_flag));
        cmp(req, "viol_addr", 64'(viol_addr), 64'(m_addr));
        cmp(req, "viol_write", 64'(viol_write), 64'(m_wr));
    endtask

    // One cycle: drive at the falling edge, check combinational outputs, then update model at the rising edge.
    task automatic step(logic v, logic [31:0] a, logic w, logic t, logic clr, logic [31:0] d);
        bit pass, refused;
        req_valid = v; req_addr = a; req_write = w; req_trusted = t;
        clear_viol = clr; req_wdata = d;
        #1;
        pass    = v && exp_pass(a, w, t);
        refused = v && !exp_pass(a, w, t);
        if (!v) begin
            cmp("R9", "mem_req idle", 64'(mem_req), 64'd0);
        end else begin
            cmp(tag_of(a, w, t), "mem_req", 64'(mem_req), 64'(pass));
            cmp(tag_of(a, w, t), "req_refused", 64'(req_refused), 64'(refused));
            if (pass) begin
                cmp("R9", "mem_addr", 64'(mem_addr), 64'(a));
                cmp("R9", "mem_write", 64'(mem_write), 64'(w));
                cmp("R9", "mem_wdata", 64'(mem_wdata), 64'(d));
            end
        end
        @(posedge clk);
        if (clr) begin m_flag = 0; m_wr = 0; m_addr = '0; end
        if (refused && (!m_flag || clr)) begin m_flag = 1; m_wr = w; m_addr = a; end
        @(negedge clk);
        check_record(clr ? "R8" : "R7");
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit seed_dummy;
        seed_dummy = 0;
        void'($urandom(32'h5EED_1220));
        repeat (3) @(negedge clk);
        check_record("R10");
        rst_n = 1'b1;
        @(negedge clk);
        check_record("R10");

        // Directed window bounds
        step(1, 32'hA000_0000, 0, 0, 0, 32'h1);   // R2
        step(1, 32'hA000_FFFF, 1, 0, 0, 32'h2);   // R3
        step(1, 32'hA001_0000, 0, 0, 0, 32'h3);   // R4
        step(1, 32'hA001_FFFF, 0, 0, 0, 32'h4);   // R4
        step(1, 32'hA001_0000, 1, 0, 0, 32'h5);   // R5 first offender
        step(1, 32'h9FFF_FFFF, 0, 0, 0, 32'h6);   // R6, record keeps first (R7)
        step(1, 32'hA002_0000, 1, 0, 0, 32'h7);   // R6
        step(1, 32'hA001_8000, 1, 1, 0, 32'h8);   // R1 trusted write to read-only window
        step(1, 32'h0000_0000, 1, 1, 0, 32'h9);   // R1 outside windows
        step(0, 32'hA000_0010, 1, 0, 0, 32'hA);   // R9 idle
        step(0, 32'h0, 0, 0, 1, 32'h0);           // R8 clear alone
        step(1, 32'hA001_0004, 1, 0, 0, 32'hB);   // R5 new offender
        step(1, 32'hA001_FFFF, 1, 0, 1, 32'hC);   // R8 refusal in clear cycle
        step(0, 32'h0, 0, 0, 1, 32'h0);           // R8

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a;
            case ($urandom % 5)
                0: a = 32'hA000_0000 + ($urandom % 32'h1_0000);
                1: a = 32'hA001_0000 + ($urandom % 32'h1_0000);
                2: a = 32'hA000_0000 + ($urandom % 32'h2_0000) - 32'd2;
                3: a = ($urandom % 2) ? 32'hA001_FFFF + ($urandom % 3) : 32'h9FFF_FFFE + ($urandom % 3);
                default: a = $urandom;
            endcase
            step(($urandom % 8) != 0, a, $urandom % 2, ($urandom % 4) == 0,
                 ($urandom % 16) == 0, $urandom);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule